// File: doc/BRIEF.md
# Nibble RAM Select and Status Group

This block models a bank of four-bit data RAM chips that a processor reaches in two steps. A select command first latches an 8-bit address. That address names a chip, a register within that chip, and a character within that register. Each later memory command then works on that latched location until the next select command. The commands are: read or write the main character, read or write one of four status characters per register, write the selected chip's latched output port, and add or subtract the selected character with the accumulator.

The processor side presents one command per cycle. Each command carries a 4-bit code, a valid flag, the address, the accumulator and the carry. Reads and arithmetic results come back combinationally in the same cycle. Writes and selects take effect at the next rising clock edge. Each chip has one 4-bit output port, and it holds its value until that chip receives another port write.

Top module: `nram_group`

## Requirements
- R1: Command code 1 (select) latches addr_i at the next clock edge. Bits [7:6] are the chip, bits [5:4] are the register and bits [3:0] are the character. The latched value applies to every later command until the next select.
- R2: When cmd_valid_i is 0, no storage, port or select state changes, whatever the code on cmd_i.
- R3: Code 2 writes acc_i into the selected main character at the next edge. Code 8 drives that character on rd_data_o in the same cycle. Reads leave memory unchanged.
- R4: Codes 4 to 7 write acc_i into status character cmd_i[1:0] of the selected chip and register. Codes 12 to 15 read status character cmd_i[1:0] on rd_data_o in the same cycle. The character field of the select is ignored.
- R5: Code 3 writes acc_i into the selected chip's port, port_o[4*chip+3 : 4*chip], with acc_i bit 0 on the lowest bit. The value holds until the next port write to that same chip. The other chips' ports keep their values.
- R6: Code 9 gives {alu_carry_o, alu_sum_o} = acc_i + character + carry_i in the same cycle.
- R7: Code 10 gives {alu_carry_o, alu_sum_o} = acc_i + ~character + carry_i. Carry 1 means "no borrow", both on the input and on the output.
- R8: rd_data_o is 0 unless a valid read (code 8 or 12 to 15) is present. alu_sum_o and alu_carry_o are 0 unless a valid code 9 or 10 is present.
- R9: An active-low reset clears all main characters, all status characters, all ports and the select register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 4 | Command code |
| addr_i | input | 8 | Address for the select command |
| acc_i | input | 4 | Accumulator value |
| carry_i | input | 1 | Carry in (1 = no borrow for subtract) |
| rd_data_o | output | 4 | Read data for main or status reads |
| port_o | output | 16 | Output ports, 4 bits per chip |
| alu_sum_o | output | 4 | Add or subtract result |
| alu_carry_o | output | 1 | Add or subtract carry out |

## Verification
Read data and arithmetic results are combinational, so the bench samples them a quarter period after it drives a command, before the clock edge. Selects, memory writes and port writes appear one edge later. The bench therefore checks them only through a command issued in the following cycle, or by sampling port_o after that edge. Status writes and main writes are read back under a different select, to show that the character field and the status index choose locations independently.

// File: rtl/nram_pkg.sv
package nram_pkg;
  localparam int STAT_IDX_W = 2;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_SEL    = 4'd1,
    CMD_WR_MN  = 4'd2,
    CMD_WR_PRT = 4'd3,
    CMD_WR_ST0 = 4'd4,
    CMD_WR_ST1 = 4'd5,
    CMD_WR_ST2 = 4'd6,
    CMD_WR_ST3 = 4'd7,
    CMD_RD_MN  = 4'd8,
    CMD_ADD    = 4'd9,
    CMD_SUB    = 4'd10,
    CMD_RSV    = 4'd11,
    CMD_RD_ST0 = 4'd12,
    CMD_RD_ST1 = 4'd13,
    CMD_RD_ST2 = 4'd14,
    CMD_RD_ST3 = 4'd15
  } cmd_e;
endpackage

// File: rtl/nram_sel.sv
module nram_sel #(
  parameter int SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] addr_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= '0;
    else if (load_i) sel_o <= addr_i;
  end
endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int MAIN_IW = 8,
  parameter int STAT_IW = 6,
  parameter int DATA_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               main_we_i,
  input  logic               stat_we_i,
  input  logic [MAIN_IW-1:0] main_idx_i,
  input  logic [STAT_IW-1:0] stat_idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  main_rd_o,
  output logic [DATA_W-1:0]  stat_rd_o
);
  localparam int MAIN_N = 1 << MAIN_IW;
  localparam int STAT_N = 1 << STAT_IW;

  logic [DATA_W-1:0] main_q [MAIN_N];
  logic [DATA_W-1:0] stat_q [STAT_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAIN_N; i++) main_q[i] <= '0;
    end else if (main_we_i) begin
      main_q[main_idx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAT_N; i++) stat_q[i] <= '0;
    end else if (stat_we_i) begin
      stat_q[stat_idx_i] <= wdata_i;
    end
  end

  assign main_rd_o = main_q[main_idx_i];
  assign stat_rd_o = stat_q[stat_idx_i];
endmodule

// File: rtl/nram_ports.sv
module nram_ports #(
  parameter int CHIP_W = 2,
  parameter int DATA_W = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CHIP_W-1:0]                chip_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [(1<<CHIP_W)*DATA_W-1:0]    port_o
);
  localparam int NUM_CHIPS = 1 << CHIP_W;

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    logic hit;
    assign hit = we_i && (chip_i == CHIP_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  port_o[c*DATA_W +: DATA_W] <= '0;
      else if (hit) port_o[c*DATA_W +: DATA_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/nram_alu.sv
module nram_alu #(
  parameter int DATA_W = 4
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] opnd;
  logic [DATA_W:0]   tot;

  // subtract: carry 1 = no borrow, so the ones' complement plus carry-in suffices
  assign opnd = sub_i ? ~mem_i : mem_i;
  assign tot  = {1'b0, acc_i} + {1'b0, opnd} + {{DATA_W{1'b0}}, carry_i};
  assign sum_o   = tot[DATA_W-1:0];
  assign carry_o = tot[DATA_W];
endmodule

// File: rtl/nram_group.sv
module nram_group
  import nram_pkg::*;
#(
  parameter int CHIP_W = 2,
  parameter int REG_W  = 2,
  parameter int CHAR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic [3:0]                    cmd_i,
  input  logic [CHIP_W+REG_W+CHAR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]             acc_i,
  input  logic                          carry_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [(1<<CHIP_W)*DATA_W-1:0] port_o,
  output logic [DATA_W-1:0]             alu_sum_o,
  output logic                          alu_carry_o
);
  localparam int SEL_W   = CHIP_W + REG_W + CHAR_W;
  localparam int LOC_W   = CHIP_W + REG_W;
  localparam int STAT_IW = LOC_W + STAT_IDX_W;

  cmd_e op;
  logic do_sel, do_wmain, do_wport, do_wstat, do_rmain, do_rstat, do_add, do_sub;
  logic [SEL_W-1:0]   sel_q;
  logic [STAT_IW-1:0] stat_idx;
  logic [DATA_W-1:0]  main_rd, stat_rd, sum;
  logic               cout;

  assign op = cmd_e'(cmd_i);

  always_comb begin
    do_sel   = 1'b0;
    do_wmain = 1'b0;
    do_wport = 1'b0;
    do_wstat = 1'b0;
    do_rmain = 1'b0;
    do_rstat = 1'b0;
    do_add   = 1'b0;
    do_sub   = 1'b0;
    if (cmd_valid_i) begin
      unique case (op)
        CMD_SEL:    do_sel   = 1'b1;
        CMD_WR_MN:  do_wmain = 1'b1;
        CMD_WR_PRT: do_wport = 1'b1;
        CMD_WR_ST0, CMD_WR_ST1, CMD_WR_ST2, CMD_WR_ST3: do_wstat = 1'b1;
        CMD_RD_MN:  do_rmain = 1'b1;
        CMD_ADD:    do_add   = 1'b1;
        CMD_SUB:    do_sub   = 1'b1;
        CMD_RD_ST0, CMD_RD_ST1, CMD_RD_ST2, CMD_RD_ST3: do_rstat = 1'b1;
        default: ;
      endcase
    end
  end

  // status index: chip and register from the select, slot from opcode
  assign stat_idx = {sel_q[SEL_W-1 -: LOC_W], cmd_i[STAT_IDX_W-1:0]};

  nram_sel #(.SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_sel),
    .addr_i (addr_i),
    .sel_o  (sel_q)
  );

  nram_store #(.MAIN_IW(SEL_W), .STAT_IW(STAT_IW), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .main_we_i  (do_wmain),
    .stat_we_i  (do_wstat),
    .main_idx_i (sel_q),
    .stat_idx_i (stat_idx),
    .wdata_i    (acc_i),
    .main_rd_o  (main_rd),
    .stat_rd_o  (stat_rd)
  );

  nram_ports #(.CHIP_W(CHIP_W), .DATA_W(DATA_W)) u_ports (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (do_wport),
    .chip_i  (sel_q[SEL_W-1 -: CHIP_W]),
    .wdata_i (acc_i),
    .port_o  (port_o)
  );

  nram_alu #(.DATA_W(DATA_W)) u_alu (
    .sub_i   (do_sub),
    .acc_i   (acc_i),
    .mem_i   (main_rd),
    .carry_i (carry_i),
    .sum_o   (sum),
    .carry_o (cout)
  );

  always_comb begin
    rd_data_o = '0;
    if (do_rmain)      rd_data_o = main_rd;
    else if (do_rstat) rd_data_o = stat_rd;
  end

  assign alu_sum_o   = (do_add || do_sub) ? sum  : '0;
  assign alu_carry_o = (do_add || do_sub) ? cout : 1'b0;
endmodule

// File: rtl/nram_group_chk.sv
module nram_group_chk #(
  parameter int CHIP_W = 2,
  parameter int REG_W  = 2,
  parameter int CHAR_W = 4,
  parameter int DATA_W = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cmd_valid_i,
  input logic [3:0]                     cmd_i,
  input logic [CHIP_W+REG_W+CHAR_W-1:0] addr_i,
  input logic [DATA_W-1:0]              acc_i,
  input logic                           carry_i,
  input logic [CHIP_W+REG_W+CHAR_W-1:0] sel_q,
  input logic [DATA_W-1:0]              rd_data_o,
  input logic [(1<<CHIP_W)*DATA_W-1:0]  port_o,
  input logic [DATA_W-1:0]              alu_sum_o,
  input logic                           alu_carry_o
);
  localparam int SEL_W = CHIP_W + REG_W + CHAR_W;

  logic [CHIP_W-1:0] last_chip;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_chip <= '0;
    else         last_chip <= sel_q[SEL_W-1 -: CHIP_W];
  end

  a_r1_sel_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 4'd1) |=> sel_q == $past(addr_i));

  a_r1_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_i == 4'd1) |=> $stable(sel_q));

  a_r5_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_i == 4'd3) |=> $stable(port_o));

  a_r5_port_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 4'd3) |=>
      port_o[int'(last_chip)*DATA_W +: DATA_W] == $past(acc_i));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> (rd_data_o == '0 && alu_sum_o == '0 && !alu_carry_o));

  a_r6_add_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 4'd9 && acc_i == '0 && !carry_i) |-> !alu_carry_o);
endmodule

bind nram_group nram_group_chk #(
  .CHIP_W(CHIP_W), .REG_W(REG_W), .CHAR_W(CHAR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .addr_i      (addr_i),
  .acc_i       (acc_i),
  .carry_i     (carry_i),
  .sel_q       (sel_q),
  .rd_data_o   (rd_data_o),
  .port_o      (port_o),
  .alu_sum_o   (alu_sum_o),
  .alu_carry_o (alu_carry_o)
);

// File: tb/nram_group_tb.sv
module nram_group_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [3:0]  cmd = '0;
  logic [7:0]  addr = '0;
  logic [3:0]  acc = '0;
  logic        cy = 1'b0;
  logic [3:0]  rd, sum;
  logic [15:0] port;
  logic        cout;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nram_group u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v), .cmd_i(cmd), .addr_i(addr),
    .acc_i(acc), .carry_i(cy), .rd_data_o(rd), .port_o(port),
    .alu_sum_o(sum), .alu_carry_o(cout)
  );

  // {valid, cmd, addr, acc, carry, exp_rd, exp_sum, exp_carry}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 4'd1,  8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 select 0
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R3 read reset value
    {1'b1, 4'd2,  8'h00, 4'h5, 1'b0, 4'h0, 4'h0, 1'b0}, // R3 write 5
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h5, 4'h0, 1'b0}, // R3 read 5
    {1'b1, 4'd9,  8'h00, 4'h3, 1'b1, 4'h0, 4'h9, 1'b0}, // R6 3+5+1
    {1'b1, 4'd9,  8'h00, 4'hF, 1'b1, 4'h0, 4'h5, 1'b1}, // R6 F+5+1
    {1'b1, 4'd10, 8'h00, 4'h7, 1'b1, 4'h0, 4'h2, 1'b1}, // R7 7-5
    {1'b1, 4'd10, 8'h00, 4'h3, 1'b1, 4'h0, 4'hE, 1'b0}, // R7 3-5 borrow
    {1'b1, 4'd10, 8'h00, 4'h7, 1'b0, 4'h0, 4'h1, 1'b1}, // R7 7-5-1
    {1'b1, 4'd1,  8'hD3, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 chip3 reg1 char3
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 fresh location
    {1'b1, 4'd2,  8'h00, 4'hA, 1'b0, 4'h0, 4'h0, 1'b0}, // R3 write A
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'hA, 4'h0, 1'b0}, // R3 read A
    {1'b1, 4'd6,  8'h00, 4'hC, 1'b0, 4'h0, 4'h0, 1'b0}, // R4 status2 <- C
    {1'b1, 4'd14, 8'h00, 4'h0, 1'b0, 4'hC, 4'h0, 1'b0}, // R4 status2
    {1'b1, 4'd13, 8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R4 status1 untouched
    {1'b1, 4'd1,  8'hD7, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R4 other char
    {1'b1, 4'd14, 8'h00, 4'h0, 1'b0, 4'hC, 4'h0, 1'b0}, // R4 char ignored
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 char 7 empty
    {1'b1, 4'd1,  8'h03, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 chip0 reg0
    {1'b1, 4'd14, 8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R4 other register
    {1'b1, 4'd1,  8'h00, 4'h0, 1'b0, 4'h0, 4'h0, 1'b0}, // R1 back to 0
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h5, 4'h0, 1'b0}, // R3 unchanged by ALU
    {1'b0, 4'd2,  8'h00, 4'hF, 1'b0, 4'h0, 4'h0, 1'b0}, // R2 R8 invalid write
    {1'b1, 4'd8,  8'h00, 4'h0, 1'b0, 4'h5, 4'h0, 1'b0}, // R2 still 5
    {1'b0, 4'd9,  8'h00, 4'h7, 1'b1, 4'h0, 4'h0, 1'b0}, // R8 invalid add
    {1'b1, 4'd9,  8'h00, 4'h0, 1'b0, 4'h0, 4'h5, 1'b0}  // R6 0+5+0
  };

  task automatic drive(input logic vv, input logic [3:0] c, input logic [7:0] a,
                       input logic [3:0] ac, input logic cc);
    @(negedge clk);
    v = vv; cmd = c; addr = a; acc = ac; cy = cc;
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset ports", 32'(port), 32'h0);
    check("R9 reset outputs", 32'({rd, sum, cout}), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][26], VEC[i][25:22], VEC[i][21:14], VEC[i][13:10], VEC[i][9]);
      check($sformatf("R3/R4/R6/R7/R8 vector %0d", i),
            32'({rd, sum, cout}), 32'(VEC[i][8:0]));
    end

    // R5 port writes
    drive(1'b1, 4'd1, 8'h80, 4'h0, 1'b0);
    drive(1'b1, 4'd3, 8'h00, 4'h6, 1'b0);
    drive(1'b0, 4'd0, 8'h00, 4'h0, 1'b0);
    check("R5 chip2 port", 32'(port), 32'h0600);
    drive(1'b1, 4'd1, 8'h40, 4'h0, 1'b0);
    drive(1'b1, 4'd3, 8'h00, 4'h9, 1'b0);
    drive(1'b1, 4'd2, 8'h00, 4'h3, 1'b0);
    check("R5 chip1 port, chip2 held", 32'(port), 32'h0690);
    drive(1'b0, 4'd3, 8'h00, 4'hF, 1'b0);
    drive(1'b0, 4'd0, 8'h00, 4'h0, 1'b0);
    check("R2 invalid port write", 32'(port), 32'h0690);
    drive(1'b1, 4'd3, 8'h00, 4'h1, 1'b0);
    drive(1'b0, 4'd0, 8'h00, 4'h0, 1'b0);
    check("R5 chip1 rewrite", 32'(port), 32'h0610);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check("R9 ports cleared", 32'(port), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 4'd8, 8'h00, 4'h0, 1'b0);
    check("R9 select cleared, main 0", 32'(rd), 32'h0);
    drive(1'b1, 4'd1, 8'hD3, 4'h0, 1'b0);
    drive(1'b1, 4'd14, 8'h00, 4'h0, 1'b0);
    check("R9 status cleared", 32'(rd), 32'h0);
    drive(1'b1, 4'd8, 8'h00, 4'h0, 1'b0);
    check("R9 main cleared", 32'(rd), 32'h0);
    drive(1'b0, 4'd0, 8'h00, 4'h0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule